// File: doc/BRIEF.md
# Packet-Command PIO Read Sequencer

This block is the device side of a packet-style read command whose data is handed to the host over programmed I/O, one 16-bit word per data-register read. The host first loads a 16-bit byte-count limit as two byte registers, then writes the packet command opcode. The block collects a 12-byte command packet as six word writes and decodes a block read request with a 32-bit starting block address and a 16-bit block count. It then streams the requested blocks from a simple media read port.

The data phase is divided into bursts. Each burst moves no more bytes than the limit with bit 0 cleared. Every burst opens with an interrupt and a data-request status. When the last word has been read, the block raises a final interrupt and returns to an idle-ready status. The media port is combinational: the block presents a block address and a word index, and the media returns the word in the same cycle.

The sequencer has five named states. IDLE (ready, waiting for a command) goes to PKT on the packet opcode. PKT (collecting packet words) goes to DECODE after the sixth word. DECODE (busy) goes to IDLE on a bad opcode or a zero count, and otherwise to PREP. PREP (busy, sizing the next burst) always goes to XFER. XFER (data request) goes to PREP at the end of a burst and to IDLE at the end of the command.

Top module: `atapi_pio_seq`

## Requirements
- R1: After reset the status register (address 7) reads 0x40 (ready), the error register (address 1) reads 0 and the interrupt is low.
- R2: In IDLE, writing 0xA0 to address 7 starts a command, and status then reads 0x48 (data request and ready). Any other value written to address 7 is ignored: status stays 0x40 and no interrupt is raised.
- R3: The packet is taken from six writes to address 0. Within each word the low byte is the earlier packet byte. After the sixth write, status reads 0xC0 (busy and ready) for one cycle while the packet is decoded.
- R4: Packet byte 0 is the opcode; 0x28 selects block read. Bytes 2 to 5 hold the starting block address with the most significant byte first. Bytes 7 and 8 hold the block count with the most significant byte first.
- R5: Data words come out in order, starting at word 0 of the starting block. Each block is 1024 words (2048 bytes). After the last word of a block, the next word is word 0 of the following block address.
- R6: The burst size in bytes is the limit (address 4 low byte, address 5 high byte) with bit 0 cleared. A limit of 0 or 1 is treated as 0xFFFE. Each burst carries that many bytes, or the bytes that remain if fewer, so the number of bursts is the total rounded up.
- R7: At the start of each burst the interrupt is high and status reads 0x48.
- R8: After the last data word the interrupt is raised and status reads 0x40.
- R9: Reading status at address 7 clears a pending interrupt. Reading the alternate status at address 14 returns the same value and leaves the interrupt pending.
- R10: A block count of 0 ends the command with no data phase: only the final interrupt is raised, with status 0x40.
- R11: An opcode other than 0x28 ends the command with the interrupt raised, status 0x41 (ready and error) and the error register reading 0x04 (abort). The next accepted packet command clears both.
- R12: Addresses 4 and 5 read back the limit bytes last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_wr_addr | input | 4 | Register address of the write |
| host_wr_data | input | 16 | Write data (bytes use bits 7:0) |
| host_rd | input | 1 | Host register read strobe; side effects take place at the clock edge |
| host_rd_addr | input | 4 | Register address of the read |
| host_rd_data | output | 16 | Read data for the addressed register, combinational |
| irq | output | 1 | Pending interrupt |
| media_lba | output | 32 | Block address presented to the media |
| media_word | output | BLOCK_SHIFT-1 | Word index within the block |
| media_data | input | 16 | Media word for the presented address |

## Verification
The bench sets limits that do not divide the transfer evenly. These include an odd limit, a limit of 2 (one word per burst) and a limit of 0, which must become 0xFFFE; a design that failed to clear bit 0 or to substitute 0xFFFE would give the wrong burst count or the wrong final-burst length. Transfers cross block boundaries, and one starts at an address near the top of the 32-bit range; a wrong carry or a byte swap in the packet decode shows up as corrupted words. The bench also covers a zero block count, which must not open a data phase; a bad opcode, which must leave the error bits set until the next command; and the rule that an alternate-status read leaves the interrupt pending while a status read clears it.

// File: rtl/atapi_seq_pkg.sv
package atapi_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PKT,
        ST_DECODE,
        ST_PREP,
        ST_XFER
    } seq_state_t;

    // host register map
    localparam logic [3:0] RA_DATA     = 4'd0;
    localparam logic [3:0] RA_ERROR    = 4'd1;
    localparam logic [3:0] RA_LIMIT_LO = 4'd4;
    localparam logic [3:0] RA_LIMIT_HI = 4'd5;
    localparam logic [3:0] RA_CMDSTAT  = 4'd7;
    localparam logic [3:0] RA_ALTSTAT  = 4'd14;

    // status bit positions
    localparam int SB_BSY  = 7;
    localparam int SB_DRDY = 6;
    localparam int SB_DRQ  = 3;
    localparam int SB_ERR  = 0;

    localparam logic [7:0] OP_PACKET = 8'hA0;
    localparam logic [7:0] OP_READ10 = 8'h28;
    localparam logic [7:0] ERR_ABORT = 8'h04;

    // widths fixed by the packet layout
    localparam int LBA_W   = 32;
    localparam int COUNT_W = 16;
    localparam int LIMIT_W = 16;

endpackage

// File: rtl/atapi_cdb_capture.sv
module atapi_cdb_capture #(
    parameter int CDB_WORDS = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        wr_word,
    input  logic [15:0] wr_data,
    output logic        last_word,
    output logic [7:0]  opcode,
    output logic [31:0] lba,
    output logic [15:0] blocks
);
    localparam int CNT_W = $clog2(CDB_WORDS + 1);

    logic [CNT_W-1:0] cnt;
    logic [15:0]      words [CDB_WORDS];

    genvar g;
    generate
        for (g = 0; g < CDB_WORDS; g++) begin : g_word
            always_ff @(posedge clk) begin
                if (!rst_n)
                    words[g] <= '0;
                else if (wr_word && cnt == CNT_W'(g))
                    words[g] <= wr_data;
            end
        end
    endgenerate

    assign last_word = wr_word && (cnt == CNT_W'(CDB_WORDS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (wr_word)
            cnt <= last_word ? '0 : cnt + 1'b1;
    end

    // R4: low byte of each word is the earlier packet byte, fields big-endian
    assign opcode = words[0][7:0];
    assign lba    = {words[1][7:0], words[1][15:8], words[2][7:0], words[2][15:8]};
    assign blocks = {words[3][15:8], words[4][7:0]};

    logic unused_cdb_bits;
    assign unused_cdb_bits = ^{words[0][15:8], words[3][7:0], words[4][15:8], words[CDB_WORDS-1]};

    // R3: the word counter never runs past the packet length
    a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(CDB_WORDS));

endmodule

// File: rtl/atapi_burst_planner.sv
module atapi_burst_planner #(
    parameter int LIMIT_W     = 16,
    parameter int COUNT_W     = 16,
    parameter int BLOCK_SHIFT = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [COUNT_W-1:0] blocks,
    input  logic [LIMIT_W-1:0] limit,
    input  logic               plan,
    input  logic               take,
    output logic               burst_end,
    output logic               all_end
);
    localparam int REM_W = COUNT_W + BLOCK_SHIFT;

    logic [LIMIT_W-1:0] eff;
    logic [REM_W-1:0]   rem;
    logic [REM_W-1:0]   burst_bytes;
    logic [LIMIT_W-1:0] burst_left;

    // R6: clear bit 0; a limit below 2 becomes the largest even value
    always_comb begin
        if (limit[LIMIT_W-1:1] == '0)
            eff = {{(LIMIT_W-1){1'b1}}, 1'b0};
        else
            eff = {limit[LIMIT_W-1:1], 1'b0};
        burst_bytes = (rem < REM_W'(eff)) ? rem : REM_W'(eff);
    end

    assign burst_end = take && (burst_left == LIMIT_W'(1));
    assign all_end   = take && (rem == REM_W'(2));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem        <= '0;
            burst_left <= '0;
        end else if (load) begin
            rem        <= {blocks, {BLOCK_SHIFT{1'b0}}};
            burst_left <= '0;
        end else if (plan) begin
            burst_left <= LIMIT_W'(burst_bytes >> 1);
        end else if (take) begin
            rem        <= rem - REM_W'(2);
            burst_left <= burst_left - 1'b1;
        end
    end

    // R6: a burst in progress never exceeds the effective limit
    a_r6_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_left != '0) |-> ({burst_left, 1'b0} <= {1'b0, eff}));

    // R6: words are only taken while both counters still hold data
    a_r6_take_ok: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (burst_left != '0 && rem != '0));

    // R8: the last word of the command also closes its burst
    a_r8_end_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        all_end |-> burst_end);

endmodule

// File: rtl/atapi_word_stream.sv
module atapi_word_stream #(
    parameter int WIDX_W = 10,
    parameter int LBA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LBA_W-1:0]  lba_in,
    input  logic              step,
    output logic [LBA_W-1:0]  cur_lba,
    output logic [WIDX_W-1:0] cur_widx
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_lba  <= '0;
            cur_widx <= '0;
        end else if (load) begin
            cur_lba  <= lba_in;
            cur_widx <= '0;
        end else if (step) begin
            if (&cur_widx) begin
                cur_widx <= '0;
                cur_lba  <= cur_lba + LBA_W'(1);
            end else begin
                cur_widx <= cur_widx + 1'b1;
            end
        end
    end

    // R5: leaving the last word of a block moves to word 0 of the next block
    a_r5_block_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && &cur_widx) |=> (cur_widx == '0 && cur_lba == $past(cur_lba) + LBA_W'(1)));

endmodule

// File: rtl/atapi_pio_seq.sv
module atapi_pio_seq
    import atapi_seq_pkg::*;
#(
    parameter int BLOCK_SHIFT = 11,
    parameter int CDB_WORDS   = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_wr,
    input  logic [3:0]             host_wr_addr,
    input  logic [15:0]            host_wr_data,
    input  logic                   host_rd,
    input  logic [3:0]             host_rd_addr,
    output logic [15:0]            host_rd_data,
    output logic                   irq,
    output logic [LBA_W-1:0]       media_lba,
    output logic [BLOCK_SHIFT-2:0] media_word,
    input  logic [15:0]            media_data
);
    localparam int WIDX_W = BLOCK_SHIFT - 1;

    seq_state_t state, state_nx;

    logic [7:0]  lim_lo, lim_hi, err_code;
    logic        err_flag, irq_q;
    logic [7:0]  status;

    logic        cdb_clear, ld, plan, irq_set, err_set;
    logic        last_word, burst_end, all_end;
    logic [7:0]  opcode;
    logic [31:0] cdb_lba;
    logic [15:0] cdb_blocks;

    logic wr_cmd, pkt_go, data_wr, data_rd, status_rd;

    assign wr_cmd    = host_wr && host_wr_addr == RA_CMDSTAT;
    assign pkt_go    = state == ST_IDLE && wr_cmd && host_wr_data[7:0] == OP_PACKET;
    assign data_wr   = host_wr && host_wr_addr == RA_DATA && state == ST_PKT;
    assign data_rd   = host_rd && host_rd_addr == RA_DATA && state == ST_XFER;
    assign status_rd = host_rd && host_rd_addr == RA_CMDSTAT;

    atapi_cdb_capture #(.CDB_WORDS(CDB_WORDS)) i_cdb (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cdb_clear),
        .wr_word   (data_wr),
        .wr_data   (host_wr_data),
        .last_word (last_word),
        .opcode    (opcode),
        .lba       (cdb_lba),
        .blocks    (cdb_blocks)
    );

    atapi_burst_planner #(
        .LIMIT_W     (LIMIT_W),
        .COUNT_W     (COUNT_W),
        .BLOCK_SHIFT (BLOCK_SHIFT)
    ) i_plan (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld),
        .blocks    (cdb_blocks),
        .limit     ({lim_hi, lim_lo}),
        .plan      (plan),
        .take      (data_rd),
        .burst_end (burst_end),
        .all_end   (all_end)
    );

    atapi_word_stream #(.WIDX_W(WIDX_W), .LBA_W(LBA_W)) i_stream (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .lba_in   (cdb_lba),
        .step     (data_rd),
        .cur_lba  (media_lba),
        .cur_widx (media_word)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // next state and per-state outputs
    always_comb begin
        state_nx  = state;
        cdb_clear = 1'b0;
        ld        = 1'b0;
        plan      = 1'b0;
        irq_set   = 1'b0;
        err_set   = 1'b0;
        status    = 8'h00;
        unique case (state)
            ST_IDLE: begin
                cdb_clear           = 1'b1;
                status[SB_DRDY]     = 1'b1;
                status[SB_ERR]      = err_flag;
                if (pkt_go)
                    state_nx = ST_PKT;
            end
            ST_PKT: begin
                status[SB_DRDY] = 1'b1;
                status[SB_DRQ]  = 1'b1;
                if (last_word)
                    state_nx = ST_DECODE;
            end
            ST_DECODE: begin
                status[SB_BSY]  = 1'b1;
                status[SB_DRDY] = 1'b1;
                if (opcode != OP_READ10) begin
                    err_set  = 1'b1;
                    irq_set  = 1'b1;
                    state_nx = ST_IDLE;
                end else if (cdb_blocks == '0) begin
                    irq_set  = 1'b1;
                    state_nx = ST_IDLE;
                end else begin
                    ld       = 1'b1;
                    state_nx = ST_PREP;
                end
            end
            ST_PREP: begin
                status[SB_BSY]  = 1'b1;
                status[SB_DRDY] = 1'b1;
                plan            = 1'b1;
                irq_set         = 1'b1;
                state_nx        = ST_XFER;
            end
            ST_XFER: begin
                status[SB_DRDY] = 1'b1;
                status[SB_DRQ]  = 1'b1;
                if (burst_end) begin
                    if (all_end) begin
                        irq_set  = 1'b1;
                        state_nx = ST_IDLE;
                    end else begin
                        state_nx = ST_PREP;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // host-visible registers and interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_lo   <= '0;
            lim_hi   <= '0;
            err_flag <= 1'b0;
            err_code <= '0;
            irq_q    <= 1'b0;
        end else begin
            if (state == ST_IDLE && host_wr && host_wr_addr == RA_LIMIT_LO)
                lim_lo <= host_wr_data[7:0];
            if (state == ST_IDLE && host_wr && host_wr_addr == RA_LIMIT_HI)
                lim_hi <= host_wr_data[7:0];
            if (err_set) begin
                err_flag <= 1'b1;
                err_code <= ERR_ABORT;
            end else if (pkt_go) begin
                err_flag <= 1'b0;
                err_code <= '0;
            end
            if (irq_set)
                irq_q <= 1'b1;
            else if (status_rd || pkt_go)
                irq_q <= 1'b0;
        end
    end

    assign irq = irq_q;

    always_comb begin
        case (host_rd_addr)
            RA_DATA:     host_rd_data = (state == ST_XFER) ? media_data : 16'h0000;
            RA_ERROR:    host_rd_data = {8'h00, err_code};
            RA_LIMIT_LO: host_rd_data = {8'h00, lim_lo};
            RA_LIMIT_HI: host_rd_data = {8'h00, lim_hi};
            RA_CMDSTAT,
            RA_ALTSTAT:  host_rd_data = {8'h00, status};
            default:     host_rd_data = 16'h0000;
        endcase
    end

    // R7: every burst opens with the interrupt pending in the data-request state
    a_r7_burst_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PREP) |=> (irq && state == ST_XFER));

    // R8: the final word raises the completion interrupt
    a_r8_final_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && state_nx == ST_IDLE) |=> irq);

    // R9: a status read in idle clears the interrupt
    a_r9_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && status_rd && !host_wr) |=> !irq);

    // R9: an alternate-status read in idle leaves the interrupt pending
    a_r9_alt_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && irq && host_rd && host_rd_addr == RA_ALTSTAT && !host_wr) |=> irq);

    // R2: a command other than the packet opcode leaves the sequencer idle
    a_r2_ignore_other: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_cmd && host_wr_data[7:0] != OP_PACKET) |=> (state == ST_IDLE && !irq));

endmodule

// File: tb/test_atapi_pio_seq.sv
module test_atapi_pio_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [3:0]  host_wr_addr = '0;
    logic [15:0] host_wr_data = '0;
    logic        host_rd = 1'b0;
    logic [3:0]  host_rd_addr = '0;
    logic [15:0] host_rd_data;
    logic        irq;
    logic [31:0] media_lba;
    logic [9:0]  media_word;
    logic [15:0] media_data;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    function automatic logic [15:0] media_fn(input logic [31:0] l, input logic [9:0] w);
        return l[15:0] ^ {w, 6'b0} ^ 16'hA5C3;
    endfunction

    assign media_data = media_fn(media_lba, media_word);

    atapi_pio_seq i_atapi_pio_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr      (host_wr),
        .host_wr_addr (host_wr_addr),
        .host_wr_data (host_wr_data),
        .host_rd      (host_rd),
        .host_rd_addr (host_rd_addr),
        .host_rd_data (host_rd_data),
        .irq          (irq),
        .media_lba    (media_lba),
        .media_word   (media_word),
        .media_data   (media_data)
    );

    // {limit, lba, count, expected bursts, expected words in last burst}
    localparam logic [95:0] VECS [6] = '{
        {16'd5120, 32'h0000_0000, 16'd1,  16'd1,    16'd1024},
        {16'd5120, 32'h0000_0010, 16'd10, 16'd4,    16'd2560},
        {16'd5121, 32'h1234_5678, 16'd3,  16'd2,    16'd512},
        {16'd2,    32'h0000_0005, 16'd1,  16'd1024, 16'd1},
        {16'd0,    32'hFFFF_FFF0, 16'd33, 16'd2,    16'd1025},
        {16'd3000, 32'h0000_00C8, 16'd2,  16'd2,    16'd548}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_wr_addr = a; host_wr_data = d;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic hr(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_rd_addr = a;
        #1 d = host_rd_data;
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic wait_irq(output bit got);
        got = 1'b0;
        for (int i = 0; i < 16 && !got; i++) begin
            @(negedge clk); #1;
            got = irq;
        end
    endtask

    task automatic send_cmd(input logic [15:0] lim, input logic [31:0] lba,
                            input logic [15:0] cnt, input logic [7:0] op, input bit chk_pkt);
        logic [15:0] s;
        hw(4'd4, {8'h00, lim[7:0]});
        hw(4'd5, {8'h00, lim[15:8]});
        hw(4'd7, 16'h00A0);
        if (chk_pkt) begin
            hr(4'd7, s);
            chk(s == 16'h0048, "R2 status awaiting packet", s, 16'h0048);
        end
        hw(4'd0, {8'h00, op});
        hw(4'd0, {lba[23:16], lba[31:24]});
        hw(4'd0, {lba[7:0], lba[15:8]});
        hw(4'd0, {cnt[15:8], 8'h00});
        hw(4'd0, {8'h00, cnt[7:0]});
        hw(4'd0, 16'h0000);
    endtask

    task automatic run_vec(input int k);
        logic [15:0] lim, cnt, exp_bursts, exp_last, s, d, e;
        logic [31:0] lba;
        int rem, bursts, last_n, st_bad, mism, idx, n;
        logic [15:0] first_act, first_exp;
        bit got;
        {lim, lba, cnt, exp_bursts, exp_last} = VECS[k];
        e = lim & 16'hFFFE;
        if (e == 16'h0) e = 16'hFFFE;
        rem = int'(cnt) * 2048;
        bursts = 0; last_n = 0; st_bad = 0; mism = 0; idx = 0;
        first_act = '0; first_exp = '0;
        send_cmd(lim, lba, cnt, 8'h28, 1'b0);
        while (rem > 0) begin
            wait_irq(got);
            if (!got) begin
                chk(1'b0, "R7 burst interrupt missing", 0, 1);
                break;
            end
            hr(4'd7, s);
            if (s != 16'h0048) st_bad++;
            n = ((rem < int'(e)) ? rem : int'(e)) / 2;
            for (int j = 0; j < n; j++) begin
                logic [15:0] ex;
                hr(4'd0, d);
                ex = media_fn(lba + 32'(idx / 1024), 10'(idx % 1024));
                if (d != ex) begin
                    if (mism == 0) begin first_act = d; first_exp = ex; end
                    mism++;
                end
                idx++;
            end
            rem -= 2 * n;
            bursts++;
            last_n = n;
        end
        chk(bursts == int'(exp_bursts), "R6 burst count", bursts, exp_bursts);
        chk(last_n == int'(exp_last), "R6 last burst words", last_n, exp_last);
        chk(st_bad == 0, "R7 burst start status", st_bad, 0);
        chk(mism == 0, "R4 R5 data words", first_act, first_exp);
        wait_irq(got);
        chk(got, "R8 final interrupt", got, 1);
        hr(4'd7, s);
        chk(s == 16'h0040, "R8 final status", s, 16'h0040);
        @(negedge clk); #1;
        chk(irq == 1'b0, "R9 status read clears irq", irq, 0);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] s;
        bit got;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        hr(4'd7, s);
        chk(s == 16'h0040, "R1 reset status", s, 16'h0040);
        hr(4'd1, s);
        chk(s == 16'h0000, "R1 reset error", s, 0);
        chk(irq == 1'b0, "R1 reset irq", irq, 0);

        // R12 limit readback
        hw(4'd4, 16'h0034);
        hw(4'd5, 16'h0012);
        hr(4'd4, s);
        chk(s == 16'h0034, "R12 limit low readback", s, 16'h34);
        hr(4'd5, s);
        chk(s == 16'h0012, "R12 limit high readback", s, 16'h12);

        // R2 other command ignored
        hw(4'd7, 16'h00EC);
        hr(4'd7, s);
        chk(s == 16'h0040, "R2 other opcode ignored", s, 16'h0040);
        chk(irq == 1'b0, "R2 no irq on other opcode", irq, 0);

        // R11 unsupported packet opcode
        send_cmd(16'd5120, 32'h0, 16'd1, 8'h12, 1'b0);
        wait_irq(got);
        chk(got, "R11 error interrupt", got, 1);
        hr(4'd14, s);
        chk(s == 16'h0041, "R11 error status via alt", s, 16'h0041);
        @(negedge clk); #1;
        chk(irq == 1'b1, "R9 alt status keeps irq", irq, 1);
        hr(4'd1, s);
        chk(s == 16'h0004, "R11 abort code", s, 16'h0004);
        hr(4'd7, s);
        chk(s == 16'h0041, "R11 error status", s, 16'h0041);
        @(negedge clk); #1;
        chk(irq == 1'b0, "R9 status read clears irq", irq, 0);

        // R10 zero count, R3 busy after packet, R11 error cleared
        send_cmd(16'd5120, 32'h0000_0100, 16'd0, 8'h28, 1'b1);
        hr(4'd7, s);
        chk(s == 16'h00C0, "R3 busy while decoding", s, 16'h00C0);
        @(negedge clk); #1;
        chk(irq == 1'b1, "R10 zero count interrupt", irq, 1);
        hr(4'd7, s);
        chk(s == 16'h0040, "R10 zero count status", s, 16'h0040);
        hr(4'd1, s);
        chk(s == 16'h0000, "R11 error cleared by next packet", s, 0);

        // R4 R5 R6 R7 R8 vector table
        for (int k = 0; k < 6; k++) run_vec(k);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule